// File: doc/BRIEF.md
# AES column-mix byte cell

This block is one storage-and-compute cell of a 4x4 AES state array. It holds a single state byte in an 8-bit register. From the four bytes of its column it computes one output byte of either the forward or the inverse column mix, and it XORs a round-key byte into that result in the same cycle. The four-byte column multiplier is shared between the two directions: the inverse product is formed as the forward product plus two extra doubling terms, so there is no second full multiplier.

Sixteen copies of the cell form a state array, each with its row number set by the `ROW` parameter. A surrounding sequencer, outside this block, steers the cells with a load-source select. The cell can hold its value, take a byte from its vertical neighbour, take a byte from its horizontal neighbour, or load the computed round result. A mix-enable input turns the multiplier off for the final round, so that only the key XOR is applied there.

Top module: `mcb_byte_cell`

## Requirements
- R1: While `rst_n` is low the stored byte `q` is 8'h00, and it is still 8'h00 at the first clock edge after reset is released.
- R2: With `src_sel` = 2'b00 (HOLD), `q` keeps its value at the clock edge, whatever the column, key, neighbour, `dec` and `mix_en` inputs are.
- R3: With `src_sel` = 2'b01 (VERT), `q` takes `vert_in` at the clock edge.
- R4: With `src_sel` = 2'b10 (HORZ), `q` takes `horz_in` at the clock edge.
- R5: With `src_sel` = 2'b11 (CALC), `mix_en` = 1 and `dec` = 0, `q` takes 02*c[ROW] ^ 03*c[ROW+1] ^ c[ROW+2] ^ c[ROW+3] ^ `key_in`. Here c[i] is `col_in[8*i +: 8]`, the indices wrap modulo 4, and the products are in GF(2^8) reduced by x^8+x^4+x^3+x+1 (8'h1B).
- R6: With `src_sel` = 2'b11, `mix_en` = 1 and `dec` = 1, `q` takes 0E*c[ROW] ^ 0B*c[ROW+1] ^ 0D*c[ROW+2] ^ 09*c[ROW+3] ^ `key_in`, using the same indexing and field as R5.
- R7: With `src_sel` = 2'b11 and `mix_en` = 0, `q` takes the previous `q` ^ `key_in`. `col_in` and `dec` have no effect.
- R8: The byte of the column that takes the leading coefficient (02 or 0E) is the one at index `ROW`. A cell with a different `ROW` gives a different result from the same column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_in | input | 32 | Column bytes; byte i at bits [8i+7:8i] is row i |
| key_in | input | 8 | Round-key byte for this cell |
| vert_in | input | 8 | Byte from the vertical neighbour |
| horz_in | input | 8 | Byte from the horizontal neighbour |
| dec | input | 1 | 1 selects the inverse column mix |
| mix_en | input | 1 | 1 applies the column multiply; 0 is key XOR only |
| src_sel | input | 2 | Load source: 00 HOLD, 01 VERT, 10 HORZ, 11 CALC |
| q | output | 8 | Stored state byte |

## Verification
The column multiply and the key XOR land in the same clock edge. Every CALC load therefore has to show both effects at once. The bench drives CALC loads with nonzero keys in both directions and compares `q` against a product that a plain shift-and-add field multiplier computes separately, XORed with the key. Known column vectors with a zero key isolate the multiply. Bypass loads isolate the XOR on the stored byte, and they use columns and `dec` values chosen so that a leak of the multiplier into the result would show.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    localparam int BYTE_W = 8;
    localparam int COL_N  = 4;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'b00,
        SRC_VERT = 2'b01,
        SRC_HORZ = 2'b10,
        SRC_CALC = 2'b11
    } src_e;

    // multiply by {02} in GF(2^8)
    function automatic logic [BYTE_W-1:0] dbl(input logic [BYTE_W-1:0] b);
        return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? RED_POLY : '0);
    endfunction
endpackage

// File: rtl/mcb_gf_mult.sv
module mcb_gf_mult
    import mcb_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic [COL_N*BYTE_W-1:0] col,
    input  logic                    dec,
    output logic [BYTE_W-1:0]       prod
);
    logic [BYTE_W-1:0] a [COL_N];

    // rotate column so a[0] is this cell's own row
    for (genvar g = 0; g < COL_N; g++) begin : g_rot
        assign a[g] = col[((g + ROW) % COL_N)*BYTE_W +: BYTE_W];
    end

    logic [BYTE_W-1:0] fwd, all_sum, even_sum, corr;

    always_comb begin
        fwd      = dbl(a[0]) ^ dbl(a[1]) ^ a[1] ^ a[2] ^ a[3];
        all_sum  = a[0] ^ a[1] ^ a[2] ^ a[3];
        even_sum = a[0] ^ a[2];
        // inverse coefficients minus forward ones: {0C},{08},{0C},{08}
        corr     = dbl(dbl(even_sum)) ^ dbl(dbl(dbl(all_sum)));
        prod     = dec ? (fwd ^ corr) : fwd;
    end
endmodule

// File: rtl/mcb_round_mix.sv
module mcb_round_mix
    import mcb_pkg::*;
(
    input  logic [BYTE_W-1:0] prod,
    input  logic [BYTE_W-1:0] own,
    input  logic [BYTE_W-1:0] key,
    input  logic              mix_en,
    output logic [BYTE_W-1:0] res
);
    always_comb begin
        res = (mix_en ? prod : own) ^ key;
    end
endmodule

// File: rtl/mcb_src_sel.sv
module mcb_src_sel
    import mcb_pkg::*;
(
    input  src_e              sel,
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] vert,
    input  logic [BYTE_W-1:0] horz,
    input  logic [BYTE_W-1:0] calc,
    output logic [BYTE_W-1:0] nxt
);
    always_comb begin
        unique case (sel)
            SRC_HOLD: nxt = cur;
            SRC_VERT: nxt = vert;
            SRC_HORZ: nxt = horz;
            SRC_CALC: nxt = calc;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/mcb_byte_cell.sv
module mcb_byte_cell
    import mcb_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COL_N*BYTE_W-1:0] col_in,
    input  logic [BYTE_W-1:0]       key_in,
    input  logic [BYTE_W-1:0]       vert_in,
    input  logic [BYTE_W-1:0]       horz_in,
    input  logic                    dec,
    input  logic                    mix_en,
    input  logic [1:0]              src_sel,
    output logic [BYTE_W-1:0]       q
);
    logic [BYTE_W-1:0] prod, res, nxt, q_r;

    mcb_gf_mult #(.ROW(ROW)) u_mult (
        .col  (col_in),
        .dec  (dec),
        .prod (prod)
    );

    mcb_round_mix u_mix (
        .prod   (prod),
        .own    (q_r),
        .key    (key_in),
        .mix_en (mix_en),
        .res    (res)
    );

    mcb_src_sel u_sel (
        .sel  (src_e'(src_sel)),
        .cur  (q_r),
        .vert (vert_in),
        .horz (horz_in),
        .calc (res),
        .nxt  (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= nxt;
    end

    always_comb begin
        q = q_r;
    end
endmodule

// File: rtl/mcb_byte_cell_chk.sv
module mcb_byte_cell_chk
    import mcb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] key_in,
    input logic [BYTE_W-1:0] vert_in,
    input logic [BYTE_W-1:0] horz_in,
    input logic              mix_en,
    input logic [1:0]        src_sel,
    input logic [BYTE_W-1:0] q
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_HOLD) |=> $stable(q));

    a_r3_vert_load: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_VERT) |=> (q == $past(vert_in)));

    a_r4_horz_load: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_HORZ) |=> (q == $past(horz_in)));

    a_r7_bypass_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_CALC && !mix_en) |=> (q == ($past(q) ^ $past(key_in))));
endmodule

bind mcb_byte_cell mcb_byte_cell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_in  (key_in),
    .vert_in (vert_in),
    .horz_in (horz_in),
    .mix_en  (mix_en),
    .src_sel (src_sel),
    .q       (q)
);

// File: tb/mcb_byte_cell_bench.sv
module mcb_byte_cell_bench;
    localparam int CELL_ROW = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] col_in = '0;
    logic [7:0]  key_in = '0, vert_in = '0, horz_in = '0;
    logic        dec = 1'b0, mix_en = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [7:0]  q;

    int checks = 0, errors = 0;
    logic [7:0] model_q = 8'h00;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    mcb_byte_cell #(.ROW(CELL_ROW)) u_mcb_byte_cell (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .key_in(key_in),
        .vert_in(vert_in), .horz_in(horz_in), .dec(dec), .mix_en(mix_en),
        .src_sel(src_sel), .q(q)
    );

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p, x, y;
        p = 8'h00; x = a; y = b;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] cb(input logic [31:0] c, input int i);
        return c[8*(i % 4) +: 8];
    endfunction

    function automatic logic [7:0] mix_ref(input logic [31:0] c, input logic d, input int r);
        if (!d)
            return gm(8'h02, cb(c, r)) ^ gm(8'h03, cb(c, r+1)) ^ cb(c, r+2) ^ cb(c, r+3);
        return gm(8'h0E, cb(c, r)) ^ gm(8'h0B, cb(c, r+1))
             ^ gm(8'h0D, cb(c, r+2)) ^ gm(8'h09, cb(c, r+3));
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected q
    task automatic step(input logic [1:0] s, input logic [31:0] c, input logic [7:0] k,
                        input logic [7:0] v, input logic [7:0] h,
                        input logic d, input logic m, input string tag);
        @(negedge clk);
        src_sel = s; col_in = c; key_in = k; vert_in = v; horz_in = h;
        dec = d; mix_en = m;
        case (s)
            2'b00: model_q = model_q;
            2'b01: model_q = v;
            2'b10: model_q = h;
            default: model_q = m ? (mix_ref(c, d, CELL_ROW) ^ k) : (model_q ^ k);
        endcase
        exp_q.push_back(model_q);
        tag_q.push_back(tag);
    endtask

    // monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), q, exp_q.pop_front());
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1 check("R1 in reset", q, 8'h00);
        #10 rst_n = 1'b1;
        step(2'b00, 32'hFFFF_FFFF, 8'hAA, 8'h55, 8'h66, 1'b1, 1'b1, "R1 after release");

        // R3, R4 neighbour loads
        step(2'b01, '0, 8'h00, 8'hC3, 8'h3C, 1'b0, 1'b0, "R3 vertical");
        step(2'b10, '0, 8'h00, 8'h11, 8'h7E, 1'b0, 1'b0, "R4 horizontal");
        // R2 hold with everything else toggling
        step(2'b00, 32'hDEAD_BEEF, 8'hFF, 8'h01, 8'h02, 1'b0, 1'b1, "R2 hold a");
        step(2'b00, 32'h1234_5678, 8'h5A, 8'hF0, 8'h0F, 1'b1, 1'b0, "R2 hold b");

        // R5 known column db 13 53 45 -> row1 of forward mix is 4d
        step(2'b11, 32'h4553_13DB, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R5 known vector");
        check("R5 literal 4d", model_q, 8'h4D);
        // R6 known column 8e 4d a1 bc -> row1 of inverse mix is 13
        step(2'b11, 32'hBCA1_4D8E, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R6 known vector");
        check("R6 literal 13", model_q, 8'h13);
        // R5/R6 with key in the same cycle
        step(2'b11, 32'h4553_13DB, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b1, "R5 mix plus key");
        step(2'b11, 32'hBCA1_4D8E, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b1, "R6 mix plus key");
        // R8 leading coefficient sits on row 1: single nonzero byte in row 1 vs row 0
        step(2'b11, 32'h0000_0100, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R8 row1 byte");
        check("R8 literal 02", model_q, 8'h02);
        step(2'b11, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R8 row0 byte");
        check("R8 literal 01", model_q, 8'h01);
        // R7 bypass: column and dec must not matter
        step(2'b01, '0, 8'h00, 8'h96, 8'h00, 1'b0, 1'b0, "R3 preload");
        step(2'b11, 32'hFFFF_FFFF, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, "R7 bypass dec");
        step(2'b11, 32'h8080_8080, 8'hF0, 8'h00, 8'h00, 1'b0, 1'b0, "R7 bypass enc");
        // GF reduction corner: all 0xFF / 0x80 columns
        step(2'b11, 32'h8080_8080, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R6 reduction");
        step(2'b11, 32'hFF80_FF80, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R5 reduction");

        for (int n = 0; n < 300; n++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            step(s, $urandom, 8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom),
                 s == 2'b00 ? "R2 random" : s == 2'b01 ? "R3 random" :
                 s == 2'b10 ? "R4 random" : "R5 R6 R7 random");
        end

        // R1 mid-run reset
        @(negedge clk);
        src_sel = 2'b00;
        rst_n = 1'b0;
        #1 check("R1 mid-run reset", q, 8'h00);
        model_q = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 32'h0, 8'h77, 8'h00, 8'h00, 1'b0, 1'b1, "R1 hold after reset");

        @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule